// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a 32-bit load/store processor whose datapath shares one ALU and one memory port across several clock cycles per instruction. It holds a small binary-coded state register and, from the state alone (Moore style), drives every select and enable the datapath needs. These include the memory address source, the instruction register load, the ALU operand and operation selects, the PC source and write enables, and the register-file write controls. The decode step sends the machine down one of five instruction paths: register-to-register arithmetic, load word, store word, branch-if-equal and jump. Each instruction takes three to five cycles and then returns to the fetch step.

Two faults are trapped. The first is an opcode that matches none of the five supported classes. The second is an arithmetic overflow reported by the ALU during a register-to-register execute step. Each fault has its own trap state. That state saves PC-4 (the faulting instruction's address) into the exception PC register, records a one-bit cause code, and steers the PC to the fixed trap vector. Every pin is a plain level signal sampled or driven once per cycle. There is no handshake: the datapath is assumed to complete every step in one cycle, so there is no back-pressure.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: An active-low `rst_n` (asynchronous) puts the machine in the fetch step at once, from any step.
- R2: Fetch drives mem_rd=1, ir_we=1, pc_we=1, alu_b_sel=01, with alu_a_sel=0, alu_op=00, pc_src=00 and addr_from_alu=0; all other outputs are 0. The next step is always decode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11, alu_op=00 with every enable at 0. The opcode sampled there selects the path: 000000 register op, 100011 load, 101011 store, 000100 branch-if-equal, 000010 jump.
- R4: A register op runs execute (alu_a_sel=1, alu_b_sel=00, alu_op=10), then write-back (reg_dst=1, wb_from_mem=0, reg_we=1), then fetch: four cycles in all.
- R5: If alu_ovf=1 in the register-op execute step, the next step is the overflow trap (exc_cause=1) instead of write-back, and reg_we stays 0 for that instruction.
- R6: A load runs address (alu_a_sel=1, alu_b_sel=10, alu_op=00), memory read (addr_from_alu=1, mem_rd=1), then write-back (reg_dst=0, wb_from_mem=1, reg_we=1): five cycles in all.
- R7: A store runs address (as in R6), then memory write (addr_from_alu=1, mem_wr=1), then fetch: four cycles in all.
- R8: Branch-if-equal executes with alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01, pc_we_if_zero=1, then returns to fetch: three cycles in all.
- R9: Jump executes with pc_src=10 and pc_we=1, then returns to fetch: three cycles in all.
- R10: Any other opcode in decode leads to the undefined-instruction trap. Each trap step drives epc_we=1, cause_we=1, pc_we=1, pc_src=11, alu_a_sel=0, alu_b_sel=01, alu_op=01, and exc_cause (0 undefined, 1 overflow), then returns to fetch.
- R11: alu_ovf has no effect in any step other than register-op execute: the sequence and outputs are unchanged.
- R12: mem_rd and mem_wr are never both 1; pc_we and pc_we_if_zero are never both 1; reg_we and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to fetch |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| reg_dst | output | 1 | 1: destination register from rd field, 0: from rt field |
| reg_we | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 register A |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| wb_from_mem | output | 1 | Register write data: 0 ALU result register, 1 memory data register |
| addr_from_alu | output | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_if_zero | output | 1 | PC write when the ALU zero flag is set |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field decides |
| alu_b_sel | output | 2 | 00 register B, 01 constant 4, 10 sign-extended offset, 11 offset shifted left 2 |
| pc_src | output | 2 | 00 ALU output, 01 ALU result register, 10 jump target, 11 trap vector |
| exc_cause | output | 1 | Cause code to record: 0 undefined opcode, 1 overflow |
| epc_we | output | 1 | Exception PC register write |
| cause_we | output | 1 | Cause register write |

## Verification
An ALU overflow and the completion of a register op fall in the same cycle. In the execute step the machine must choose between the write-back step and the overflow trap. The bench provokes this by raising alu_ovf exactly in that step for the register-op opcode, and also in every other step of every opcode. It judges the result cycle by cycle at the ports. After overflow, the trap outputs must appear at once, reg_we must never rise for that instruction, and fetch must follow. The same flag raised only outside the execute step must leave every path's sequence unchanged.

// File: rtl/mcf_pkg.sv
`timescale 1ns/1ps
package mcf_pkg;
  localparam int OPC_W = 6;
  localparam int ST_W  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    S_FETCH   = 4'd0,
    S_DECODE  = 4'd1,
    S_ADDR    = 4'd2,
    S_LD_MEM  = 4'd3,
    S_LD_WB   = 4'd4,
    S_ST_MEM  = 4'd5,
    S_R_EXE   = 4'd6,
    S_R_WB    = 4'd7,
    S_BEQ     = 4'd8,
    S_JMP     = 4'd9,
    S_TRAP_UD = 4'd10,
    S_TRAP_OV = 4'd11
  } state_t;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [SEL_W-1:0] ALU_ADD   = 2'b00;
  localparam logic [SEL_W-1:0] ALU_SUB   = 2'b01;
  localparam logic [SEL_W-1:0] ALU_FUNCT = 2'b10;

  localparam logic [SEL_W-1:0] OPB_REG    = 2'b00;
  localparam logic [SEL_W-1:0] OPB_FOUR   = 2'b01;
  localparam logic [SEL_W-1:0] OPB_IMM    = 2'b10;
  localparam logic [SEL_W-1:0] OPB_IMM_SH = 2'b11;

  localparam logic [SEL_W-1:0] PCS_ALU  = 2'b00;
  localparam logic [SEL_W-1:0] PCS_HELD = 2'b01;
  localparam logic [SEL_W-1:0] PCS_JMP  = 2'b10;
  localparam logic [SEL_W-1:0] PCS_VEC  = 2'b11;

  typedef struct packed {
    logic             reg_dst;
    logic             reg_we;
    logic             alu_a_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             wb_from_mem;
    logic             addr_from_alu;
    logic             ir_we;
    logic             pc_we;
    logic             pc_we_if_zero;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] pc_src;
    logic             exc_cause;
    logic             epc_we;
    logic             cause_we;
  } ctrl_t;
endpackage

// File: rtl/mcf_next.sv
`timescale 1ns/1ps
module mcf_next
  import mcf_pkg::*;
(
  input  state_t           cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output state_t           nxt
);
  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OPC_RTYPE: nxt = S_R_EXE;
          OPC_LOAD:  nxt = S_ADDR;
          OPC_STORE: nxt = S_ADDR;
          OPC_BEQ:   nxt = S_BEQ;
          OPC_JUMP:  nxt = S_JMP;
          default:   nxt = S_TRAP_UD;
        endcase
      end
      S_ADDR:   nxt = (opcode == OPC_LOAD) ? S_LD_MEM : S_ST_MEM;
      S_LD_MEM: nxt = S_LD_WB;
      // overflow is looked at only here; elsewhere the flag is a don't-care
      S_R_EXE:  nxt = alu_ovf ? S_TRAP_OV : S_R_WB;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcf_outputs.sv
`timescale 1ns/1ps
module mcf_outputs
  import mcf_pkg::*;
(
  input  state_t cur,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_we     = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_b_sel = OPB_FOUR;
        ctl.alu_op    = ALU_ADD;
        ctl.pc_src    = PCS_ALU;
      end
      S_DECODE: begin
        ctl.alu_b_sel = OPB_IMM_SH;
        ctl.alu_op    = ALU_ADD;
      end
      S_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = OPB_IMM;
        ctl.alu_op    = ALU_ADD;
      end
      S_LD_MEM: begin
        ctl.addr_from_alu = 1'b1;
        ctl.mem_rd        = 1'b1;
      end
      S_LD_WB: begin
        ctl.wb_from_mem = 1'b1;
        ctl.reg_we      = 1'b1;
      end
      S_ST_MEM: begin
        ctl.addr_from_alu = 1'b1;
        ctl.mem_wr        = 1'b1;
      end
      S_R_EXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = OPB_REG;
        ctl.alu_op    = ALU_FUNCT;
      end
      S_R_WB: begin
        ctl.reg_dst = 1'b1;
        ctl.reg_we  = 1'b1;
      end
      S_BEQ: begin
        ctl.alu_a_sel     = 1'b1;
        ctl.alu_b_sel     = OPB_REG;
        ctl.alu_op        = ALU_SUB;
        ctl.pc_src        = PCS_HELD;
        ctl.pc_we_if_zero = 1'b1;
      end
      S_JMP: begin
        ctl.pc_src = PCS_JMP;
        ctl.pc_we  = 1'b1;
      end
      S_TRAP_UD, S_TRAP_OV: begin
        ctl.alu_b_sel = OPB_FOUR;
        ctl.alu_op    = ALU_SUB;
        ctl.pc_src    = PCS_VEC;
        ctl.pc_we     = 1'b1;
        ctl.epc_we    = 1'b1;
        ctl.cause_we  = 1'b1;
        ctl.exc_cause = (cur == S_TRAP_OV);
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
`timescale 1ns/1ps
module mc_ctrl_fsm
  import mcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output logic             reg_dst,
  output logic             reg_we,
  output logic             alu_a_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_from_mem,
  output logic             addr_from_alu,
  output logic             ir_we,
  output logic             pc_we,
  output logic             pc_we_if_zero,
  output logic [SEL_W-1:0] alu_op,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] pc_src,
  output logic             exc_cause,
  output logic             epc_we,
  output logic             cause_we
);
  state_t st_q;
  state_t st_d;
  ctrl_t  ctl;

  mcf_next u_next (
    .cur     (st_q),
    .opcode  (opcode),
    .alu_ovf (alu_ovf),
    .nxt     (st_d)
  );

  mcf_outputs u_out (
    .cur (st_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_FETCH;
    else        st_q <= st_d;
  end

  assign reg_dst       = ctl.reg_dst;
  assign reg_we        = ctl.reg_we;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign wb_from_mem   = ctl.wb_from_mem;
  assign addr_from_alu = ctl.addr_from_alu;
  assign ir_we         = ctl.ir_we;
  assign pc_we         = ctl.pc_we;
  assign pc_we_if_zero = ctl.pc_we_if_zero;
  assign alu_op        = ctl.alu_op;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign pc_src        = ctl.pc_src;
  assign exc_cause     = ctl.exc_cause;
  assign epc_we        = ctl.epc_we;
  assign cause_we      = ctl.cause_we;

  // R2: fetch always hands over to decode
  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_we && mem_rd) |=> (alu_b_sel == OPB_IMM_SH && !pc_we && !mem_rd));

  // R5: overflow in register execute leads to the overflow trap, no write-back
  a_r5_ovf_to_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_R_EXE && alu_ovf) |=> (cause_we && exc_cause && !reg_we));

  // R8: branch completes and returns to fetch
  a_r8_beq_done: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_if_zero |=> (ir_we && mem_rd));

  // R9: jump completes and returns to fetch
  a_r9_jump_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == PCS_JMP) |=> (ir_we && mem_rd));

  // R10: a trap step lasts one cycle, then fetch
  a_r10_trap_return: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> (ir_we && !cause_we));

  // R12: no conflicting enables
  a_r12_enable_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(pc_we && pc_we_if_zero) && !(reg_we && mem_wr));
endmodule

// File: tb/mc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic       alu_ovf = 1'b0;
  logic reg_dst, reg_we, alu_a_sel, mem_rd, mem_wr, wb_from_mem, addr_from_alu;
  logic ir_we, pc_we, pc_we_if_zero, exc_cause, epc_we, cause_we;
  logic [1:0] alu_op, alu_b_sel, pc_src;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
    .reg_dst(reg_dst), .reg_we(reg_we), .alu_a_sel(alu_a_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
    .addr_from_alu(addr_from_alu), .ir_we(ir_we), .pc_we(pc_we),
    .pc_we_if_zero(pc_we_if_zero), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
    .pc_src(pc_src), .exc_cause(exc_cause), .epc_we(epc_we), .cause_we(cause_we)
  );

  // observed control word
  logic [18:0] obs;
  assign obs = {reg_dst, reg_we, alu_a_sel, mem_rd, mem_wr, wb_from_mem,
                addr_from_alu, ir_we, pc_we, pc_we_if_zero,
                alu_op, alu_b_sel, pc_src, exc_cause, epc_we, cause_we};

  localparam int B_RDST = 18, B_RWE = 17, B_ASRC = 16, B_MRD = 15, B_MWR = 14;
  localparam int B_WBM = 13, B_ADDR = 12, B_IRW = 11, B_PCW = 10, B_PCWZ = 9;
  localparam int B_CAUSE = 2, B_EPC = 1, B_CWE = 0;

  localparam int L_F = 0, L_D = 1, L_ADDR = 2, L_LMEM = 3, L_LWB = 4, L_SMEM = 5;
  localparam int L_REX = 6, L_RWB = 7, L_BEQ = 8, L_JMP = 9, L_TUD = 10, L_TOV = 11;

  function automatic logic [18:0] exp_word(int lbl);
    logic [18:0] w;
    w = '0;
    case (lbl)
      L_F:    begin w[B_MRD] = 1; w[B_IRW] = 1; w[B_PCW] = 1; w[6:5] = 2'b01; end
      L_D:    begin w[6:5] = 2'b11; end
      L_ADDR: begin w[B_ASRC] = 1; w[6:5] = 2'b10; end
      L_LMEM: begin w[B_ADDR] = 1; w[B_MRD] = 1; end
      L_LWB:  begin w[B_WBM] = 1; w[B_RWE] = 1; end
      L_SMEM: begin w[B_ADDR] = 1; w[B_MWR] = 1; end
      L_REX:  begin w[B_ASRC] = 1; w[8:7] = 2'b10; end
      L_RWB:  begin w[B_RDST] = 1; w[B_RWE] = 1; end
      L_BEQ:  begin w[B_ASRC] = 1; w[8:7] = 2'b01; w[4:3] = 2'b01; w[B_PCWZ] = 1; end
      L_JMP:  begin w[4:3] = 2'b10; w[B_PCW] = 1; end
      default: begin
        w[8:7] = 2'b01; w[6:5] = 2'b01; w[4:3] = 2'b11;
        w[B_PCW] = 1; w[B_EPC] = 1; w[B_CWE] = 1;
        w[B_CAUSE] = (lbl == L_TOV);
      end
    endcase
    return w;
  endfunction

  function automatic int next_lbl(int lbl, logic [5:0] op, logic ovf);
    case (lbl)
      L_F: return L_D;
      L_D: begin
        if (op == 6'd0) return L_REX;
        if (op == 6'd35 || op == 6'd43) return L_ADDR;
        if (op == 6'd4) return L_BEQ;
        if (op == 6'd2) return L_JMP;
        return L_TUD;
      end
      L_ADDR: return (op == 6'd35) ? L_LMEM : L_SMEM;
      L_LMEM: return L_LWB;
      L_REX:  return ovf ? L_TOV : L_RWB;
      default: return L_F;
    endcase
  endfunction

  function automatic string tag_of(int lbl, logic [5:0] op);
    case (lbl)
      L_F: return "R2";
      L_D: return "R3";
      L_ADDR: return (op == 6'd35) ? "R6" : "R7";
      L_LMEM, L_LWB: return "R6";
      L_SMEM: return "R7";
      L_REX, L_RWB: return "R4";
      L_TOV: return "R5";
      L_BEQ: return "R8";
      L_JMP: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_word(string tag, logic [18:0] exp_w);
    n_tests++;
    if (obs !== exp_w) begin
      n_fail++;
      $display("FAIL %s actual=%019b expected=%019b", tag, obs, exp_w);
    end
  endtask

  task automatic check_excl();
    n_tests++;
    if ((mem_rd && mem_wr) || (pc_we && pc_we_if_zero) || (reg_we && mem_wr)) begin
      n_fail++;
      $display("FAIL R12 actual=%019b expected=no conflicting enables", obs);
    end
  endtask

  // one instruction, overflow flag per step from mask
  task automatic run_instr(logic [5:0] op, logic [4:0] mask);
    int lbl = L_F;
    int step = 0;
    opcode = op;
    do begin
      @(negedge clk);
      // R11 tags steps where the flag is up outside register execute
      if (step > 0 && mask[step-1] && lbl != L_TOV && lbl != L_RWB)
        check_word((lbl == L_REX) ? "R4" : "R11", exp_word(lbl));
      else
        check_word(tag_of(lbl, op), exp_word(lbl));
      check_excl();
      alu_ovf = mask[step];
      lbl = next_lbl(lbl, op, mask[step]);
      step++;
    end while (lbl != L_F);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    check_word("R1", exp_word(L_F));
    @(posedge clk); #1 rst_n = 1'b1;

    // sweep every opcode under three overflow patterns (R5, R11 included)
    for (int op = 0; op < 64; op++) begin
      run_instr(op[5:0], 5'b00000);
      run_instr(op[5:0], 5'b11111);
      run_instr(op[5:0], 5'b11011);
    end

    // R1: reset in the middle of a load returns to fetch
    alu_ovf = 1'b0;
    opcode = 6'b100011;
    @(negedge clk); // fetch
    @(negedge clk); // decode
    @(negedge clk); // address
    check_word("R6", exp_word(L_ADDR));
    rst_n = 1'b0;
    #1;
    check_word("R1", exp_word(L_F));
    @(posedge clk); #1 rst_n = 1'b1;
    run_instr(6'b100011, 5'b00000);
    run_instr(6'b000000, 5'b00100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule